// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt banks into one fifteen-line interrupt source for a processor. The primary bank serves lines 0 to 7. The secondary bank serves lines 8 to 15, and its combined request is fed into primary line 2. The input pin for line 2 is therefore not used. Each bank keeps four pieces of state:

- a pending-request register
- an in-service register
- a previous-level register used for edge detection
- a rotation offset that sets the priority order

A per-bank trigger-mode register selects, line by line, whether a request is captured on a rising edge or follows the input level. A fixed write mask decides which bits of that register software can change.

The vector bases, the mask registers, the auto-end-of-interrupt controls and the non-specific end-of-interrupt strobes come from command logic outside this block. They are plain inputs here.

A priority resolver in each bank works out which line, if any, can be delivered. It does this from the unmasked pending requests, the in-service bits and the rotation offset. A small state machine drives the processor interrupt line. It has three states:

- `ST_QUIET`: the interrupt line is low.
- `ST_ASSERT`: the interrupt line is high.
- `ST_SETTLE`: the interrupt line is low for one cycle after an acknowledge.

The state machine moves between them as follows:

- An acknowledge strobe takes any state to `ST_SETTLE`.
- With no acknowledge, a deliverable line on the primary bank leads to `ST_ASSERT`.
- With no acknowledge and nothing deliverable on the primary bank, the next state is `ST_QUIET`.
- `ST_SETTLE` always lasts exactly one cycle and then re-evaluates.

The acknowledge strobe is one cycle long, and the vector it returns is valid in that same cycle.

Top module: `cascade_irq_seq`

## Requirements
- R1: After reset, `intr` is 0, `trig_mode` is 0, and an acknowledge with nothing pending returns the spurious primary vector `{mst_vbase,3'd7}`.
- R2: A rising edge on an edge-mode primary line L (L≠2) makes it pending. `intr` rises two clock edges after the input, and the acknowledge returns `{mst_vbase,L[2:0]}`.
- R3: Acknowledging an edge-mode line clears its pending bit. An input held high does not request again after the end-of-interrupt.
- R4: A line whose `trig_mode` bit is 1 is level-mode. Its pending bit follows the input one edge later, and acknowledge leaves that bit set.
- R5: A pending secondary line S (input bit 8+S) sets primary line 2 as an edge request. The acknowledge then returns `{slv_vbase,S[2:0]}` and also marks S in service on the secondary bank.
- R6: If primary line 2 is pending but the secondary bank has nothing deliverable at acknowledge time, the vector is `{slv_vbase,3'd7}`.
- R7: An acknowledge while the primary bank has nothing deliverable returns `{mst_vbase,3'd7}` and changes no state.
- R8: Priority order is line (rot), then rot+1, and so on modulo 8, where the rotation offset rot is 0 after reset. A pending line is deliverable only if its priority is strictly higher than that of every in-service line of its bank.
- R9: With auto-EOI set, acknowledge sets no in-service bit. With rotate-on-auto-EOI also set, the rotation offset becomes acknowledged line + 1 modulo 8.
- R10: `mode_wr` writes `mode_wdata` masked to the primary bank (`mode_sel`=0, writable mask 0xF8) or to the secondary bank (`mode_sel`=1, mask 0xDE). `trig_mode[7:0]` shows the primary register and `trig_mode[15:8]` the secondary one.
- R11: In the cycle after an acknowledge `intr` is 0. In every other cycle it equals the primary bank's deliverable flag from the cycle before.
- R12: A line whose bit is set in `mst_imr` or `slv_imr` is never deliverable while masked. Clearing the mask bit lets it be delivered.
- R13: A non-specific end-of-interrupt strobe clears the highest-priority in-service bit of its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; bits 7:0 primary, 15:8 secondary, bit 2 unused |
| mode_wr | input | 1 | Trigger-mode register write strobe |
| mode_sel | input | 1 | 0 selects primary, 1 secondary |
| mode_wdata | input | 8 | Trigger-mode write data |
| mst_vbase | input | 5 | Primary vector base (vector bits 7:3) |
| slv_vbase | input | 5 | Secondary vector base (vector bits 7:3) |
| mst_imr | input | 8 | Primary mask, 1 = masked |
| slv_imr | input | 8 | Secondary mask, 1 = masked |
| mst_aeoi | input | 1 | Primary auto-EOI |
| slv_aeoi | input | 1 | Secondary auto-EOI |
| mst_rot_aeoi | input | 1 | Primary rotate on auto-EOI |
| slv_rot_aeoi | input | 1 | Secondary rotate on auto-EOI |
| mst_eoi | input | 1 | Primary non-specific end-of-interrupt strobe |
| slv_eoi | input | 1 | Secondary non-specific end-of-interrupt strobe |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector returned in the acknowledge cycle |
| intr | output | 1 | Interrupt request to the processor |
| trig_mode | output | 16 | Current trigger-mode registers |

## Verification
A wrong pending, in-service or rotation bit shows up at the ports as a wrong vector on the next acknowledge. It also shows up as `intr` rising or failing to rise within two edges of the stimulus; a secondary line takes one edge more because of the cascade step. A stale in-service bit keeps lower-priority lines silent until the matching end-of-interrupt, so the bench ends every delivery with an end-of-interrupt and then checks that `intr` stays low. A wrong rotation offset appears only when two lines are pending together, so the auto-EOI test pends two lines at once after a rotating acknowledge.

// File: rtl/cas_pkg.sv
package cas_pkg;
    localparam int unsigned BANK_LINES = 8;
    localparam int unsigned VEC_W      = 8;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_ASSERT = 2'd1,
        ST_SETTLE = 2'd2
    } intr_state_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [IDX_W-1:0] rot,
    output logic             any,
    output logic [IDX_W-1:0] prio,
    output logic [IDX_W-1:0] line
);
    // Lowest rotated index wins: priority 0 is line 'rot'.
    always_comb begin : pick
        logic [IDX_W-1:0] k;
        any  = |vec;
        prio = '0;
        line = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            k = IDX_W'(i) + rot;
            if (vec[k]) begin
                prio = IDX_W'(i);
                line = k;
            end
        end
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int unsigned LINES = 8,
    parameter logic [LINES-1:0] WMASK = '1,
    parameter int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_in,
    input  logic [LINES-1:0] pulse_set,
    input  logic             mode_we,
    input  logic [LINES-1:0] mode_d,
    input  logic [LINES-1:0] imr,
    input  logic             aeoi,
    input  logic             rot_aeoi,
    input  logic             eoi,
    input  logic             take,
    output logic             valid,
    output logic [IDX_W-1:0] line,
    output logic [LINES-1:0] irr_q,
    output logic [LINES-1:0] mode_q
);
    logic [LINES-1:0] prev_q, isr_q;
    logic [IDX_W-1:0] rot_q;
    logic [LINES-1:0] irr_d, isr_d;
    logic [IDX_W-1:0] rot_d;
    logic [LINES-1:0] rise;

    logic             req_any, isr_any;
    logic [IDX_W-1:0] req_prio, isr_prio, isr_line;

    prio_pick #(.LINES(LINES)) u_req (
        .vec (irr_q & ~imr),
        .rot (rot_q),
        .any (req_any),
        .prio(req_prio),
        .line(line)
    );

    prio_pick #(.LINES(LINES)) u_isr (
        .vec (isr_q),
        .rot (rot_q),
        .any (isr_any),
        .prio(isr_prio),
        .line(isr_line)
    );

    assign valid = req_any && (!isr_any || (req_prio < isr_prio));
    assign rise  = lines_in & ~prev_q;

    // Request capture per line: level lines track the pin, edge lines latch.
    generate
        for (genvar b = 0; b < LINES; b++) begin : g_cap
            always_comb begin
                if (mode_q[b]) begin
                    irr_d[b] = lines_in[b];
                end else if (take && (line == IDX_W'(b))) begin
                    irr_d[b] = 1'b0;
                end else begin
                    irr_d[b] = irr_q[b] | rise[b] | pulse_set[b];
                end
            end
        end
    endgenerate

    always_comb begin
        isr_d = isr_q;
        rot_d = rot_q;
        if (eoi && isr_any) begin
            isr_d[isr_line] = 1'b0;
        end
        if (take) begin
            if (aeoi) begin
                if (rot_aeoi) begin
                    rot_d = line + IDX_W'(1);
                end
            end else begin
                isr_d[line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= '0;
            prev_q <= '0;
            isr_q  <= '0;
            rot_q  <= '0;
            mode_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= lines_in;
            isr_q  <= isr_d;
            rot_q  <= rot_d;
            if (mode_we) begin
                mode_q <= mode_d & WMASK;
            end
        end
    end
endmodule

// File: rtl/cascade_irq_seq.sv
module cascade_irq_seq
    import cas_pkg::*;
#(
    parameter int unsigned CAS_LINE  = 2,
    parameter logic [7:0]  MST_WMASK = 8'hF8,
    parameter logic [7:0]  SLV_WMASK = 8'hDE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_in,
    input  logic        mode_wr,
    input  logic        mode_sel,
    input  logic [7:0]  mode_wdata,
    input  logic [4:0]  mst_vbase,
    input  logic [4:0]  slv_vbase,
    input  logic [7:0]  mst_imr,
    input  logic [7:0]  slv_imr,
    input  logic        mst_aeoi,
    input  logic        slv_aeoi,
    input  logic        mst_rot_aeoi,
    input  logic        slv_rot_aeoi,
    input  logic        mst_eoi,
    input  logic        slv_eoi,
    input  logic        ack,
    output logic [7:0]  ack_vec,
    output logic        intr,
    output logic [15:0] trig_mode
);
    localparam int unsigned LINES = BANK_LINES;
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam logic [LINES-1:0] CAS_BIT = LINES'(1) << CAS_LINE;

    logic             mst_valid, slv_valid;
    logic [IDX_W-1:0] mst_line, slv_line;
    logic [LINES-1:0] mst_irr, slv_irr;
    logic [LINES-1:0] mst_mode, slv_mode;
    logic             mst_take, slv_take;
    intr_state_e      state_q, state_d;

    assign mst_take = ack && mst_valid;
    assign slv_take = mst_take && (mst_line == IDX_W'(CAS_LINE)) && slv_valid;

    irq_bank #(.LINES(LINES), .WMASK(MST_WMASK)) u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in[LINES-1:0] & ~CAS_BIT),
        .pulse_set(slv_valid ? CAS_BIT : '0),
        .mode_we  (mode_wr && !mode_sel),
        .mode_d   (mode_wdata),
        .imr      (mst_imr),
        .aeoi     (mst_aeoi),
        .rot_aeoi (mst_rot_aeoi),
        .eoi      (mst_eoi),
        .take     (mst_take),
        .valid    (mst_valid),
        .line     (mst_line),
        .irr_q    (mst_irr),
        .mode_q   (mst_mode)
    );

    irq_bank #(.LINES(LINES), .WMASK(SLV_WMASK)) u_slv (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in[2*LINES-1:LINES]),
        .pulse_set('0),
        .mode_we  (mode_wr && mode_sel),
        .mode_d   (mode_wdata),
        .imr      (slv_imr),
        .aeoi     (slv_aeoi),
        .rot_aeoi (slv_rot_aeoi),
        .eoi      (slv_eoi),
        .take     (slv_take),
        .valid    (slv_valid),
        .line     (slv_line),
        .irr_q    (slv_irr),
        .mode_q   (slv_mode)
    );

    // Next-state logic for the interrupt line.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET, ST_ASSERT, ST_SETTLE: begin
                if (ack)            state_d = ST_SETTLE;
                else if (mst_valid) state_d = ST_ASSERT;
                else                state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Outputs: interrupt line and acknowledge vector.
    always_comb begin
        intr = (state_q == ST_ASSERT);
        if (!mst_valid) begin
            ack_vec = {mst_vbase, 3'd7};
        end else if (mst_line == IDX_W'(CAS_LINE)) begin
            ack_vec = slv_valid ? {slv_vbase, slv_line} : {slv_vbase, 3'd7};
        end else begin
            ack_vec = {mst_vbase, mst_line};
        end
    end

    assign trig_mode = {slv_mode, mst_mode};
endmodule

// File: rtl/cas_checker.sv
module cas_checker #(
    parameter logic [7:0] MST_WMASK = 8'hF8,
    parameter logic [7:0] SLV_WMASK = 8'hDE
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic        intr,
    input logic [7:0]  ack_vec,
    input logic [4:0]  mst_vbase,
    input logic        mst_valid,
    input logic [2:0]  mst_line,
    input logic        slv_valid,
    input logic [7:0]  mst_irr,
    input logic [7:0]  mst_mode,
    input logic [15:0] trig_mode
);
    // R11: one low cycle after every acknowledge
    a_r11_settle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !intr);

    // R11: otherwise the line follows the primary deliverable flag
    a_r11_follow_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && mst_valid) |=> intr);

    a_r11_follow_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !mst_valid) |=> !intr);

    // R7: spurious primary vector
    a_r7_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !mst_valid) |-> (ack_vec == {mst_vbase, 3'd7}));

    // R5: secondary request lands on primary line 2
    a_r5_cascade_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_valid && !ack) |=> mst_irr[2]);

    // R3: acknowledged edge line is no longer pending
    a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && mst_valid && !mst_mode[mst_line]) |=> !mst_irr[$past(mst_line)]);

    // R10: unwritable mode bits stay zero
    a_r10_mode_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_mode[7:0] & ~MST_WMASK) == 8'h00) && ((trig_mode[15:8] & ~SLV_WMASK) == 8'h00));
endmodule

bind cascade_irq_seq cas_checker #(.MST_WMASK(MST_WMASK), .SLV_WMASK(SLV_WMASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .intr     (intr),
    .ack_vec  (ack_vec),
    .mst_vbase(mst_vbase),
    .mst_valid(mst_valid),
    .mst_line (mst_line),
    .slv_valid(slv_valid),
    .mst_irr  (mst_irr),
    .mst_mode (mst_mode),
    .trig_mode(trig_mode)
);

// File: tb/tb_cascade_irq_seq.sv
`timescale 1ns/1ps
module tb_cascade_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        mode_wr = 1'b0, mode_sel = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [4:0]  mst_vbase = 5'h04, slv_vbase = 5'h05;
    logic [7:0]  mst_imr = '0, slv_imr = '0;
    logic        mst_aeoi = 1'b0, slv_aeoi = 1'b0;
    logic        mst_rot_aeoi = 1'b0, slv_rot_aeoi = 1'b0;
    logic        mst_eoi = 1'b0, slv_eoi = 1'b0;
    logic        ack = 1'b0;
    logic [7:0]  ack_vec;
    logic        intr;
    logic [15:0] trig_mode;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cascade_irq_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .mode_wdata(mode_wdata),
        .mst_vbase(mst_vbase), .slv_vbase(slv_vbase),
        .mst_imr(mst_imr), .slv_imr(slv_imr),
        .mst_aeoi(mst_aeoi), .slv_aeoi(slv_aeoi),
        .mst_rot_aeoi(mst_rot_aeoi), .slv_rot_aeoi(slv_rot_aeoi),
        .mst_eoi(mst_eoi), .slv_eoi(slv_eoi),
        .ack(ack), .ack_vec(ack_vec), .intr(intr), .trig_mode(trig_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // Acknowledge and compare the vector in the strobe cycle.
    task automatic do_ack(input string req, input int exp);
        ack = 1'b1;
        #1;
        chk(ack_vec == 8'(exp), req, ack_vec, exp);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic eoi(input bit m, input bit s);
        mst_eoi = m; slv_eoi = s;
        cyc(1);
        mst_eoi = 1'b0; slv_eoi = 1'b0;
    endtask

    task automatic set_mode(input bit sel, input logic [7:0] d);
        mode_wr = 1'b1; mode_sel = sel; mode_wdata = d;
        cyc(1);
        mode_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk(intr == 1'b0, "R1 intr after reset", intr, 0);
        chk(trig_mode == 16'h0, "R1 trig_mode after reset", trig_mode, 0);
        do_ack("R1 spurious after reset", 8'h27);

        // R10 write masks
        set_mode(1'b0, 8'hFF);
        chk(trig_mode[7:0] == 8'hF8, "R10 primary mask", trig_mode[7:0], 8'hF8);
        set_mode(1'b1, 8'hFF);
        chk(trig_mode[15:8] == 8'hDE, "R10 secondary mask", trig_mode[15:8], 8'hDE);
        set_mode(1'b0, 8'h00);
        set_mode(1'b1, 8'h00);
        chk(trig_mode == 16'h0, "R10 cleared", trig_mode, 0);

        // R2/R3/R5/R11/R13 sweep over every usable line
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            irq_in[l] = 1'b1;
            cyc(l < 8 ? 3 : 4);
            chk(intr == 1'b1, l < 8 ? "R2 intr raised" : "R5 intr raised", intr, 1);
            if (l < 8) do_ack("R2 primary vector", 8'h20 + l);
            else       do_ack("R5 secondary vector", 8'h28 + (l - 8));
            chk(intr == 1'b0, "R11 settle cycle low", intr, 0);
            cyc(1);
            eoi(1'b1, l >= 8);
            cyc(3);
            chk(intr == 1'b0, "R3 held edge input does not re-request", intr, 0);
            irq_in[l] = 1'b0;
            cyc(1);
        end

        // R4 level mode on primary line 3
        set_mode(1'b0, 8'h08);
        irq_in[3] = 1'b1;
        cyc(3);
        do_ack("R4 level vector", 8'h23);
        eoi(1'b1, 1'b0);
        cyc(2);
        chk(intr == 1'b1, "R4 level request survives acknowledge", intr, 1);
        irq_in[3] = 1'b0;
        cyc(3);
        chk(intr == 1'b0, "R4 level request follows input low", intr, 0);
        set_mode(1'b0, 8'h00);

        // R8/R13 nesting and end-of-interrupt order
        irq_in[3] = 1'b1;
        cyc(3);
        do_ack("R8 first line", 8'h23);
        irq_in[5] = 1'b1;
        cyc(3);
        chk(intr == 1'b0, "R8 lower priority blocked by in-service", intr, 0);
        irq_in[1] = 1'b1;
        cyc(3);
        chk(intr == 1'b1, "R8 higher priority preempts", intr, 1);
        do_ack("R8 preempting vector", 8'h21);
        eoi(1'b1, 1'b0);
        cyc(3);
        chk(intr == 1'b0, "R13 eoi cleared line1 only, line3 still blocks", intr, 0);
        eoi(1'b1, 1'b0);
        cyc(3);
        chk(intr == 1'b1, "R13 second eoi releases line5", intr, 1);
        do_ack("R13 released vector", 8'h25);
        eoi(1'b1, 1'b0);
        irq_in = '0;
        cyc(2);

        // R12 masking and R7 spurious with masked request
        mst_imr = 8'h10;
        irq_in[4] = 1'b1;
        cyc(3);
        chk(intr == 1'b0, "R12 masked line silent", intr, 0);
        do_ack("R7 spurious while masked", 8'h27);
        mst_imr = 8'h00;
        cyc(3);
        chk(intr == 1'b1, "R12 unmasked line delivered", intr, 1);
        do_ack("R12 unmasked vector", 8'h24);
        eoi(1'b1, 1'b0);
        irq_in = '0;
        cyc(2);

        // R6 secondary spurious: level line 9 drops after cascade latched
        set_mode(1'b1, 8'h02);
        irq_in[9] = 1'b1;
        cyc(4);
        irq_in[9] = 1'b0;
        cyc(3);
        chk(intr == 1'b1, "R6 primary line2 still pending", intr, 1);
        do_ack("R6 secondary spurious vector", 8'h2F);
        eoi(1'b1, 1'b0);
        cyc(3);
        chk(intr == 1'b0, "R6 nothing left", intr, 0);
        set_mode(1'b1, 8'h00);

        // R9 auto-EOI with rotation
        mst_aeoi = 1'b1; mst_rot_aeoi = 1'b1;
        irq_in[3] = 1'b1;
        cyc(3);
        do_ack("R9 rotating ack", 8'h23);
        irq_in[3] = 1'b0;
        cyc(1);
        irq_in[1] = 1'b1; irq_in[5] = 1'b1;
        cyc(3);
        chk(intr == 1'b1, "R9 no in-service bit left", intr, 1);
        do_ack("R9 line5 first after rotation to 4", 8'h25);
        cyc(2);
        do_ack("R9 line1 after rotation to 6", 8'h21);
        irq_in = '0;
        mst_aeoi = 1'b0; mst_rot_aeoi = 1'b0;
        cyc(3);
        chk(intr == 1'b0, "R9 all delivered", intr, 0);
        do_reset();
        chk(intr == 1'b0, "R1 intr after second reset", intr, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule